// File: doc/BRIEF.md
# Accumulator AND Execution Unit

This block executes the bitwise AND instructions of a small 8-bit accumulator processor. It accepts an opcode byte when it is idle. The second operand comes from one of three places: one of six general registers, a byte read from memory at the address formed by the H and L registers, or an immediate byte pulled from the fetch path. The result goes into the accumulator. The flag byte is rewritten. The instruction's length and cycle count are reported with a one-cycle done pulse.

The accumulator and flag byte live inside the block. The surrounding core can set them through a load port while no instruction is running. General registers come in on one packed bus. Memory and immediate operands use a request/valid handshake. A late valid stretches the instruction past its nominal cycle count.

Top module: `acc_and_unit`

## Requirements
- R1: Opcodes 0xA0..0xA5 AND the accumulator with general registers B, C, D, E, H, L, held in bytes 0..5 of `gpr_bus`. Opcode 0xA7 ANDs the accumulator with itself, so its value does not change.
- R2: Opcode 0xA6 raises `mem_rd_req` with `mem_addr` = {H, L}. It waits for `mem_rd_valid` and takes `mem_rd_data` as the operand. Exactly one request is accepted per instruction.
- R3: Opcode 0xE6 raises `imm_req`, waits for `imm_valid` and uses `imm_data` as the operand.
- R4: `ins_len` reports 2 for 0xE6 and 1 for every other known opcode.
- R5: The cycle in which the opcode is accepted counts as cycle 1. `done` is high for one cycle, in cycle 4 for register forms and cycle 8 for the memory and immediate forms. Each cycle of waiting for a late valid adds one cycle. `ins_cycles` reports 4 or 8. `busy` is high from cycle 2 through the done cycle.
- R6: After `done`, the accumulator holds the AND result. Flag bit 7 (zero) is 1 exactly when that result is 0x00.
- R7: After every AND, flag bit 6 (subtract) is 0, bit 5 (half-carry) is 1 and bit 4 (carry) is 0, whatever their earlier values.
- R8: An opcode accepted while idle that is outside the group raises `unknown` for one cycle, in the next cycle. It leaves the accumulator and flags unchanged and does not raise `busy`.
- R9: While `busy` is high, `op_valid` is ignored: no second instruction starts and `unknown` does not pulse.
- R10: `ld_en` with `op_valid` low while idle loads `ld_acc` and `ld_flags`. Flag bits 3..0 always read 0.
- R11: After reset the accumulator and flags are 0x00, and `busy`, `done`, `unknown` and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load accumulator and flags (idle only) |
| ld_acc | input | 8 | Accumulator load value |
| ld_flags | input | 8 | Flag byte load value |
| op_valid | input | 1 | Opcode offered |
| op_code | input | 8 | Opcode byte |
| gpr_bus | input | 48 | General registers, byte i = B,C,D,E,H,L for i=0..5 |
| busy | output | 1 | Instruction in progress |
| unknown | output | 1 | Rejected opcode pulse |
| done | output | 1 | Final cycle of the instruction |
| ins_len | output | 2 | Instruction length in bytes |
| ins_cycles | output | 4 | Nominal cycle count |
| mem_rd_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address {H,L} |
| mem_rd_valid | input | 1 | Memory data valid |
| mem_rd_data | input | 8 | Memory data |
| imm_req | output | 1 | Immediate byte request |
| imm_valid | input | 1 | Immediate byte valid |
| imm_data | input | 8 | Immediate byte |
| acc | output | 8 | Accumulator |
| flags | output | 8 | Flag byte {Z,N,H,C,0000} |

## Verification
Each register form is run with a distinct pattern. The non-selected registers hold the complement of the operand, so selecting the wrong register gives a different result. The flags are preloaded with the opposite of every expected bit, which exposes any flag that is not rewritten. Memory and immediate forms are run with and without valid stalls. These runs separate a fixed cycle count from a count that waits for the handshake. Results of zero and nonzero tell the zero-flag logic apart from the constant flags.

// File: rtl/acc_and_pkg.sv
package acc_and_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_GPR  = 6;
  localparam int SEL_W    = 3;
  localparam int REG_CYC  = 4;
  localparam int LONG_CYC = 8;
  localparam int CYC_W    = $clog2(LONG_CYC + 1);

  localparam logic [SEL_W-1:0] SEL_ACC = 3'd7;

  localparam int FLG_Z = 7;
  localparam int FLG_N = 6;
  localparam int FLG_H = 5;
  localparam int FLG_C = 4;

  typedef enum logic [1:0] {
    OPK_REG = 2'd0,
    OPK_MEM = 2'd1,
    OPK_IMM = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/acc_and_decode.sv
module acc_and_decode
  import acc_and_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CW     = 4,
  parameter int SHORT  = 4,
  parameter int LONG   = 8
) (
  input  logic [DW-1:0]    opcode,
  output logic             known,
  output op_kind_e         kind,
  output logic [SEL_W-1:0] sel,
  output logic [1:0]       len,
  output logic [CW-1:0]    cyc
);
  localparam logic [DW-1:0] OPC_IMM = 8'hE6;
  localparam logic [4:0]    GRP_HI  = 5'b10100;

  logic in_group;

  always_comb begin
    in_group = (opcode[DW-1:3] == GRP_HI);
    known    = in_group || (opcode == OPC_IMM);
    sel      = opcode[2:0];
    kind     = OPK_REG;
    len      = 2'd1;
    cyc      = CW'(SHORT);
    if (opcode == OPC_IMM) begin
      kind = OPK_IMM;
      len  = 2'd2;
      cyc  = CW'(LONG);
      sel  = SEL_ACC;
    end else if (in_group && opcode[2:0] == 3'd6) begin
      kind = OPK_MEM;
      cyc  = CW'(LONG);
    end
  end
endmodule

// File: rtl/acc_and_opmux.sv
module acc_and_opmux
  import acc_and_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 6
) (
  input  logic [NREG*DW-1:0] regs,
  input  logic [DW-1:0]      acc_val,
  input  logic [SEL_W-1:0]   sel,
  output logic [DW-1:0]      operand
);
  logic [DW-1:0] masked [NREG];

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_pick
      assign masked[gi] = (sel == SEL_W'(gi)) ? regs[gi*DW +: DW] : '0;
    end
  endgenerate

  always_comb begin
    operand = '0;
    for (int i = 0; i < NREG; i++) operand = operand | masked[i];
    if (sel == SEL_ACC) operand = acc_val;
  end
endmodule

// File: rtl/acc_and_alu.sv
module acc_and_alu
  import acc_and_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] result,
  output logic [DW-1:0] flag_byte
);
  always_comb begin
    result           = lhs & rhs;
    flag_byte        = '0;
    flag_byte[FLG_Z] = (result == '0);
    flag_byte[FLG_N] = 1'b0;
    flag_byte[FLG_H] = 1'b1;
    flag_byte[FLG_C] = 1'b0;
  end
endmodule

// File: rtl/acc_and_seq.sv
module acc_and_seq
  import acc_and_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          need_ext,
  input  logic [CW-1:0] cyc_total,
  input  logic          ext_vld,
  output logic          busy,
  output logic          ext_req,
  output logic          ext_take,
  output logic          done
);
  seq_state_e    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    busy     = (state_q != ST_IDLE);
    ext_req  = (state_q == ST_WAIT);
    ext_take = ext_req && ext_vld;
    done     = (state_q == ST_RUN) && ((cnt_q + CW'(1)) == cyc_total);
    state_n  = state_q;
    cnt_n    = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        cnt_n   = CW'(1);
        state_n = need_ext ? ST_WAIT : ST_RUN;
      end
      ST_WAIT: if (ext_vld) begin
        cnt_n   = cnt_q + CW'(1);
        state_n = ST_RUN;
      end
      ST_RUN: if (done) begin
        cnt_n   = '0;
        state_n = ST_IDLE;
      end else begin
        cnt_n   = cnt_q + CW'(1);
      end
      default: begin
        state_n = ST_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  assert_one_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_take |=> !ext_req);
  assert_start_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/acc_and_unit.sv
module acc_and_unit
  import acc_and_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NREG = NUM_GPR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [DW-1:0]     ld_acc,
  input  logic [DW-1:0]     ld_flags,
  input  logic              op_valid,
  input  logic [DW-1:0]     op_code,
  input  logic [NREG*DW-1:0] gpr_bus,
  output logic              busy,
  output logic              unknown,
  output logic              done,
  output logic [1:0]        ins_len,
  output logic [CYC_W-1:0]  ins_cycles,
  output logic              mem_rd_req,
  output logic [2*DW-1:0]   mem_addr,
  input  logic              mem_rd_valid,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              imm_req,
  input  logic              imm_valid,
  input  logic [DW-1:0]     imm_data,
  output logic [DW-1:0]     acc,
  output logic [DW-1:0]     flags
);
  localparam int AW    = 2 * DW;
  localparam int IDX_H = 4;
  localparam int IDX_L = 5;

  logic             dec_known;
  op_kind_e         dec_kind;
  logic [SEL_W-1:0] dec_sel;
  logic [1:0]       dec_len;
  logic [CYC_W-1:0] dec_cyc;
  logic [DW-1:0]    mux_opnd;
  logic [DW-1:0]    alu_res, alu_flags;

  logic             accept, start, ext_vld, ext_req, ext_take;
  logic             opnd_en, ld_take;

  op_kind_e         kind_q;
  logic [1:0]       len_q;
  logic [CYC_W-1:0] cyc_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    opnd_q, opnd_n;
  logic [DW-1:0]    acc_q, acc_n;
  logic [DW-1:0]    flg_q, flg_n;
  logic             unk_q;

  acc_and_decode #(.DW(DW), .CW(CYC_W), .SHORT(REG_CYC), .LONG(LONG_CYC)) u_dec (
    .opcode(op_code), .known(dec_known), .kind(dec_kind), .sel(dec_sel),
    .len(dec_len), .cyc(dec_cyc)
  );

  acc_and_opmux #(.DW(DW), .NREG(NREG)) u_mux (
    .regs(gpr_bus), .acc_val(acc_q), .sel(dec_sel), .operand(mux_opnd)
  );

  acc_and_alu #(.DW(DW)) u_alu (
    .lhs(acc_q), .rhs(opnd_q), .result(alu_res), .flag_byte(alu_flags)
  );

  acc_and_seq #(.CW(CYC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .need_ext(dec_kind != OPK_REG),
    .cyc_total(cyc_q), .ext_vld(ext_vld), .busy(busy), .ext_req(ext_req),
    .ext_take(ext_take), .done(done)
  );

  always_comb begin
    accept  = op_valid && !busy;
    start   = accept && dec_known;
    ld_take = ld_en && !op_valid && !busy;
    ext_vld = (kind_q == OPK_MEM) ? mem_rd_valid : imm_valid;
    opnd_en = (start && dec_kind == OPK_REG) || ext_take;
    opnd_n  = ext_take ? ((kind_q == OPK_MEM) ? mem_rd_data : imm_data) : mux_opnd;
    acc_n   = acc_q;
    flg_n   = flg_q;
    if (done) begin
      acc_n = alu_res;
      flg_n = alu_flags;
    end else if (ld_take) begin
      acc_n = ld_acc;
      flg_n = {ld_flags[DW-1:4], 4'h0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OPK_REG;
      len_q  <= '0;
      cyc_q  <= '0;
      addr_q <= '0;
      opnd_q <= '0;
      acc_q  <= '0;
      flg_q  <= '0;
      unk_q  <= 1'b0;
    end else begin
      unk_q <= accept && !dec_known;
      if (start) begin
        kind_q <= dec_kind;
        len_q  <= dec_len;
        cyc_q  <= dec_cyc;
        addr_q <= {gpr_bus[IDX_H*DW +: DW], gpr_bus[IDX_L*DW +: DW]};
      end
      if (opnd_en) opnd_q <= opnd_n;
      if (done || ld_take) begin
        acc_q <= acc_n;
        flg_q <= flg_n;
      end
    end
  end

  assign unknown    = unk_q;
  assign ins_len    = len_q;
  assign ins_cycles = cyc_q;
  assign mem_rd_req = ext_req && (kind_q == OPK_MEM);
  assign imm_req    = ext_req && (kind_q == OPK_IMM);
  assign mem_addr   = addr_q;
  assign acc        = acc_q;
  assign flags      = flg_q;

  assert_fixed_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (flags[FLG_N] == 1'b0 && flags[FLG_H] == 1'b1 && flags[FLG_C] == 1'b0));
  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (flags[FLG_Z] == (acc == '0)));
  assert_unknown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unknown |-> ($stable(acc) && $stable(flags) && !busy));
  assert_low_nibble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3:0] == 4'h0);
endmodule

// File: tb/acc_and_unit_bench.sv
module acc_and_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic ld_en;
  logic [7:0] ld_acc, ld_flags;
  logic op_valid;
  logic [7:0] op_code;
  logic [47:0] gpr_bus;
  logic busy, unknown, done, mem_rd_req, imm_req;
  logic [1:0] ins_len;
  logic [3:0] ins_cycles;
  logic [15:0] mem_addr;
  logic mem_rd_valid, imm_valid;
  logic [7:0] mem_rd_data, imm_data, acc, flags;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acc_and_unit u_acc_and_unit (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_acc(ld_acc), .ld_flags(ld_flags),
    .op_valid(op_valid), .op_code(op_code), .gpr_bus(gpr_bus), .busy(busy),
    .unknown(unknown), .done(done), .ins_len(ins_len), .ins_cycles(ins_cycles),
    .mem_rd_req(mem_rd_req), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .imm_req(imm_req), .imm_valid(imm_valid),
    .imm_data(imm_data), .acc(acc), .flags(flags)
  );

  // {opcode, acc, operand, stall, expected}
  localparam logic [35:0] VEC [NV] = '{
    {8'hA0, 8'hFB, 8'h0F, 4'd0, 8'h0B},
    {8'hA1, 8'hFC, 8'h0F, 4'd0, 8'h0C},
    {8'hA2, 8'hFD, 8'h0F, 4'd0, 8'h0D},
    {8'hA3, 8'hFE, 8'h0F, 4'd0, 8'h0E},
    {8'hA4, 8'hF0, 8'h0F, 4'd0, 8'h00},
    {8'hA5, 8'hF1, 8'h0F, 4'd0, 8'h01},
    {8'hA7, 8'hAB, 8'hAB, 4'd0, 8'hAB},
    {8'hA6, 8'hAB, 8'hF0, 4'd0, 8'hA0},
    {8'hA6, 8'hFA, 8'h00, 4'd3, 8'h00},
    {8'hE6, 8'hAB, 8'h0F, 4'd0, 8'h0B},
    {8'hE6, 8'hFA, 8'h00, 4'd2, 8'h00},
    {8'hA0, 8'hFA, 8'h00, 4'd0, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] f);
    @(negedge clk);
    ld_en = 1'b1; ld_acc = a; ld_flags = f;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] opnd, input int stall,
                        input logic [7:0] exp_res);
    int cyc = 1;
    int left = stall;
    int reqs = 0;
    int base = (op == 8'hA6 || op == 8'hE6) ? 8 : 4;
    bit z = (exp_res == 8'h00);
    @(negedge clk);
    op_valid = 1'b1; op_code = op;
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 2;
    while (!done && cyc < 40) begin
      if (mem_rd_req) begin
        chk(op == 8'hA6, "R2 req only for memory form", op, 8'hA6);
        chk(mem_addr == 16'h3CC3, "R2 address from H,L", mem_addr, 16'h3CC3);
        if (left > 0) left--; else begin mem_rd_valid = 1'b1; mem_rd_data = opnd; reqs++; end
      end
      if (imm_req) begin
        chk(op == 8'hE6, "R3 req only for immediate form", op, 8'hE6);
        if (left > 0) left--; else begin imm_valid = 1'b1; imm_data = opnd; reqs++; end
      end
      @(negedge clk);
      cyc++;
      mem_rd_valid = 1'b0; imm_valid = 1'b0;
    end
    chk(cyc == base + stall, "R5 done cycle", cyc, base + stall);
    chk(ins_cycles == 4'(base), "R5 ins_cycles", ins_cycles, base);
    chk(ins_len == ((op == 8'hE6) ? 2'd2 : 2'd1), "R4 ins_len", ins_len, (op == 8'hE6) ? 2 : 1);
    if (op == 8'hA6 || op == 8'hE6) chk(reqs == 1, "R2/R3 one operand transfer", reqs, 1);
    @(negedge clk);
    chk(acc == exp_res, "R1/R6 result", acc, exp_res);
    chk(flags == {z, 3'b010, 4'h0}, "R6/R7 flags", flags, {z, 3'b010, 4'h0});
    chk(!busy && !done, "R5 idle after done", {busy, done}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_acc = '0; ld_flags = '0;
    op_valid = 1'b0; op_code = '0; gpr_bus = '0;
    mem_rd_valid = 1'b0; mem_rd_data = '0; imm_valid = 1'b0; imm_data = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(acc == 0 && flags == 0, "R11 reset acc/flags", {acc, flags}, 0);
    chk(!busy && !done && !unknown && !mem_rd_req && !imm_req, "R11 reset outputs",
        {busy, done, unknown, mem_rd_req, imm_req}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] op, a, opnd, expv;
      int st;
      {op, a, opnd, st, expv} = {VEC[i][35:12], 32'(VEC[i][11:8]), VEC[i][7:0]};
      for (int r = 0; r < 6; r++) gpr_bus[r*8 +: 8] = ~opnd;
      if (op[7:3] == 5'b10100 && op[2:0] < 3'd6) gpr_bus[op[2:0]*8 +: 8] = opnd;
      if (op == 8'hA6) begin gpr_bus[4*8 +: 8] = 8'h3C; gpr_bus[5*8 +: 8] = 8'hC3; end
      load(a, {(expv != 8'h00), 3'b101, 4'hF});
      run_op(op, opnd, st, expv);
    end

    // R10 load path and low nibble
    load(8'h5A, 8'hFF);
    chk(acc == 8'h5A, "R10 acc load", acc, 8'h5A);
    chk(flags == 8'hF0, "R10 low nibble zero", flags, 8'hF0);

    // R8 unknown opcodes leave state alone
    for (int k = 0; k < 3; k++) begin
      logic [7:0] bad;
      bad = (k == 0) ? 8'hA8 : (k == 1) ? 8'h00 : 8'hE7;
      @(negedge clk);
      op_valid = 1'b1; op_code = bad;
      @(negedge clk);
      op_valid = 1'b0;
      chk(unknown && !busy, "R8 unknown pulse, no busy", {unknown, busy}, 2);
      chk(acc == 8'h5A && flags == 8'hF0, "R8 state unchanged", {acc, flags}, 16'h5AF0);
      @(negedge clk);
      chk(!unknown, "R8 single pulse", unknown, 0);
    end

    // R9 op_valid held while busy is ignored
    gpr_bus = 48'h0;
    gpr_bus[1*8 +: 8] = 8'h3C;
    load(8'hF0, 8'h00);
    @(negedge clk);
    op_valid = 1'b1; op_code = 8'hA1;
    @(negedge clk);
    op_code = 8'h00;
    begin
      int n = 0;
      bit unk_seen = 1'b0;
      while (!done && n < 20) begin
        if (unknown || imm_req || mem_rd_req) unk_seen = 1'b1;
        @(negedge clk); n++;
      end
      op_valid = 1'b0;
      chk(!unk_seen, "R9 no reaction while busy", unk_seen, 0);
    end
    @(negedge clk);
    chk(acc == 8'h30, "R9 first instruction result", acc, 8'h30);
    chk(!unknown && !busy, "R9 no queued opcode", {unknown, busy}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule